// File: doc/BRIEF.md
# System Manageability Event Controller

This block watches over platform health and turns manageability events into interrupt pulses for the processor. A two-stage watchdog counts down from a programmable reload value. Its first expiry gives software a chance to recover through an SMI. A second expiry with no service in between means the hardware itself is stuck, so the block requests a system reset. After reset release, a boot monitor waits a bounded number of cycles for the processor's first instruction fetch and requests a reboot if that fetch never arrives.

Two more event sources share the outputs. A chassis-open switch drives an active-low input, which is synchronised and edge-detected. It raises an interrupt on a programmable destination and sets a sticky flag. An ECC error strobe carries a message code that picks one of four interrupt outputs, and a control bit can replace that code with a programmed destination. Software reaches the block through a four-address write port.

Top module: `mec_event_ctrl`

## Requirements
- R1: After reset all interrupt outputs, `reset_req` and `intrusion_flag` are low, and the watchdog is disabled, so no event occurs until it is enabled.
- R2: A write to address 0 sets the reload value and loads the counter with it (low 10 bits of `wr_data`). With reload N, setting control bit 0 (watchdog enable, address 1) gives a one-cycle `smi` pulse N+1 clock edges after the edge that takes the enabling write.
- R3: With no service after the first expiry, the counter reloads and `reset_req` rises N+1 edges after the `smi` pulse, with no second `smi`.
- R4: Any write to address 2 (kick) reloads the counter and clears the first-expiry state. The following expiry then gives an `smi` again, not a reset request, and kicks made more often than every N+1 cycles prevent any expiry.
- R5: While the enable bit is low the counter holds its value and raises no event. On re-enable, counting resumes from the held value.
- R6: `reset_req` stays high once set, whatever writes arrive, until `rst_n` is asserted.
- R7: If `first_fetch` is not seen, `reset_req` rises at exactly the BOOT_LIMIT-th clock edge after reset release.
- R8: A `first_fetch` strobe sampled at or before that edge disarms the boot monitor for good, and no reboot request follows.
- R9: A falling edge on `intruder_n` gives one `smi` pulse when control bit 1 is 0, or one `tco_irq` pulse when it is 1. The pulse appears at the third clock edge after the fall, and holding the input low does not repeat it.
- R10: `intrusion_flag` goes high with the intrusion pulse and stays high until a write to address 3.
- R11: An `ecc_valid` strobe gives a one-cycle pulse at the next edge on the output chosen by `ecc_code`: 0 = `smi`, 1 = `nmi`, 2 = `serr`, 3 = `tco_irq`. No other output pulses.
- R12: When control bit 2 is set, the ECC destination comes from control bits 5:4 (same encoding) and `ecc_code` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control, 2 kick, 3 intrusion clear |
| wr_data | input | DATA_W | Write data |
| first_fetch | input | 1 | Processor first instruction fetch strobe |
| intruder_n | input | 1 | Chassis-open switch, active low, asynchronous |
| ecc_valid | input | 1 | ECC error message strobe |
| ecc_code | input | 2 | ECC message destination code |
| smi | output | 1 | SMI pulse |
| nmi | output | 1 | NMI pulse |
| serr | output | 1 | SERR pulse |
| tco_irq | output | 1 | TCO interrupt pulse |
| reset_req | output | 1 | Sticky system reset request |
| intrusion_flag | output | 1 | Sticky intrusion status |

## Verification
The watchdog is swept over reload values 0 to 6. Measuring both expiry intervals for each value separates an off-by-one in the countdown from a wrong reload after the first expiry. Separate runs with kicks, with a mid-count disable and with reset requests left standing tell apart the first-expiry clear, counter hold and stickiness. The ECC router is tried with all 32 combinations of override bit, programmed destination and message code, so a swapped encoding or an ignored override shows up on a specific output. The boot monitor is tried with no fetch and with a fetch on the very last allowed edge, and the intruder path with both destinations and a held-low input.

// File: rtl/mec_pkg.sv
package mec_pkg;

    typedef enum logic [1:0] {
        DEST_SMI  = 2'd0,
        DEST_NMI  = 2'd1,
        DEST_SERR = 2'd2,
        DEST_TCO  = 2'd3
    } dest_e;

    localparam logic [1:0] ADDR_RELOAD = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_KICK   = 2'd2;
    localparam logic [1:0] ADDR_ICLR   = 2'd3;

    localparam int CTRL_WD_EN     = 0;
    localparam int CTRL_INTR_TCO  = 1;
    localparam int CTRL_ECC_OVR   = 2;
    localparam int CTRL_ROUTE_LSB = 4;
    localparam int CTRL_MSB       = CTRL_ROUTE_LSB + 1;

    typedef struct packed {
        logic  wd_en;
        logic  intr_tco;
        logic  ecc_ovr;
        dest_e ecc_route;
    } ctrl_t;

    typedef struct packed {
        logic smi;
        logic nmi;
        logic serr;
        logic tco;
    } irq_t;

endpackage

// File: rtl/mec_watchdog.sv
module mec_watchdog #(
    parameter int          CNT_W   = 10,
    parameter logic [CNT_W-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             kick,
    output logic             smi_evt,
    output logic             rst_evt
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        smi_evt = 1'b0;
        rst_evt = 1'b0;
        if (load) begin
            st_d.reload = load_val;
            st_d.cnt    = load_val;
        end else if (kick) begin
            st_d.cnt   = st_q.reload;
            st_d.fired = 1'b0;
        end else if (en) begin
            if (st_q.cnt == '0) begin
                if (!st_q.fired) begin
                    smi_evt    = 1'b1;
                    st_d.fired = 1'b1;
                    st_d.cnt   = st_q.reload;
                end else begin
                    rst_evt = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{reload: RST_VAL, cnt: RST_VAL, fired: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_WD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load && !kick) |=> $stable(st_q.cnt)); // R5
    AST_WD_KICK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_evt); // R4
    AST_WD_SINGLE_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        smi_evt |=> !smi_evt); // R3

endmodule

// File: rtl/mec_boot_mon.sv
module mec_boot_mon #(
    parameter int CNT_W = 16,
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch,
    output logic timeout_evt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } bm_state_t;

    bm_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        timeout_evt = 1'b0;
        if (st_q.armed) begin
            if (fetch) begin
                st_d.armed = 1'b0;
            end else if (st_q.cnt == LAST) begin
                st_d.armed  = 1'b0;
                timeout_evt = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_BOOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !st_q.armed); // R8
    AST_BOOT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> !timeout_evt); // R7

endmodule

// File: rtl/mec_intrusion.sv
module mec_intrusion #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic intr_n,
    input  logic clr,
    output logic fall_evt,
    output logic flag
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   flag;
    } in_state_t;

    in_state_t st_d, st_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_comb begin
                st_d.sync = {st_q.sync[SYNC_STAGES-2:0], intr_n};
            end
        end else begin : g_single
            always_comb begin
                st_d.sync = intr_n;
            end
        end
    endgenerate

    always_comb begin
        fall_evt  = st_q.prev & ~st_q.sync[SYNC_STAGES-1];
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        st_d.flag = fall_evt | (st_q.flag & ~clr);
    end

    assign flag = st_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, prev: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_INTR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt); // R9
    AST_INTR_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R10

endmodule

// File: rtl/mec_ecc_router.sv
module mec_ecc_router
    import mec_pkg::*;
(
    input  logic       strobe,
    input  logic [1:0] code,
    input  logic       ovr,
    input  dest_e      route,
    output irq_t       hit
);

    dest_e sel;

    always_comb begin
        sel  = ovr ? route : dest_e'(code);
        hit  = '0;
        if (strobe) begin
            unique case (sel)
                DEST_SMI:  hit.smi  = 1'b1;
                DEST_NMI:  hit.nmi  = 1'b1;
                DEST_SERR: hit.serr = 1'b1;
                DEST_TCO:  hit.tco  = 1'b1;
                default:   hit      = '0;
            endcase
        end
    end

    always_comb begin
        AST_ECC_ONEHOT: assert ($onehot0(hit)); // R11
    end

endmodule

// File: rtl/mec_event_ctrl.sv
module mec_event_ctrl
    import mec_pkg::*;
#(
    parameter int WD_W        = 10,
    parameter int BOOT_W      = 16,
    parameter int BOOT_LIMIT  = 50000,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              first_fetch,
    input  logic              intruder_n,
    input  logic              ecc_valid,
    input  logic [1:0]        ecc_code,
    output logic              smi,
    output logic              nmi,
    output logic              serr,
    output logic              tco_irq,
    output logic              reset_req,
    output logic              intrusion_flag
);

    localparam logic [WD_W-1:0] WD_RST = '1;

    typedef struct packed {
        ctrl_t ctrl;
        irq_t  irq;
        logic  rst_req;
    } top_state_t;

    top_state_t st_d, st_q;

    logic we_reload, we_ctrl, we_kick, we_iclr;
    logic wd_smi, wd_rst, boot_to, intr_fall;
    irq_t ecc_hit;
    logic unused_hi;

    assign we_reload = wr_en && (wr_addr == ADDR_RELOAD);
    assign we_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    assign we_kick   = wr_en && (wr_addr == ADDR_KICK);
    assign we_iclr   = wr_en && (wr_addr == ADDR_ICLR);
    assign unused_hi = ^wr_data[DATA_W-1:WD_W];

    mec_watchdog #(.CNT_W(WD_W), .RST_VAL(WD_RST)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (st_q.ctrl.wd_en),
        .load     (we_reload),
        .load_val (wr_data[WD_W-1:0]),
        .kick     (we_kick),
        .smi_evt  (wd_smi),
        .rst_evt  (wd_rst)
    );

    mec_boot_mon #(.CNT_W(BOOT_W), .LIMIT(BOOT_LIMIT)) u_boot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch       (first_fetch),
        .timeout_evt (boot_to)
    );

    mec_intrusion #(.SYNC_STAGES(SYNC_STAGES)) u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .intr_n   (intruder_n),
        .clr      (we_iclr),
        .fall_evt (intr_fall),
        .flag     (intrusion_flag)
    );

    mec_ecc_router u_ecc (
        .strobe (ecc_valid),
        .code   (ecc_code),
        .ovr    (st_q.ctrl.ecc_ovr),
        .route  (st_q.ctrl.ecc_route),
        .hit    (ecc_hit)
    );

    always_comb begin
        st_d = st_q;
        if (we_ctrl) begin
            st_d.ctrl.wd_en     = wr_data[CTRL_WD_EN];
            st_d.ctrl.intr_tco  = wr_data[CTRL_INTR_TCO];
            st_d.ctrl.ecc_ovr   = wr_data[CTRL_ECC_OVR];
            st_d.ctrl.ecc_route = dest_e'(wr_data[CTRL_MSB:CTRL_ROUTE_LSB]);
        end
        st_d.irq.smi  = wd_smi | (intr_fall & ~st_q.ctrl.intr_tco) | ecc_hit.smi;
        st_d.irq.nmi  = ecc_hit.nmi;
        st_d.irq.serr = ecc_hit.serr;
        st_d.irq.tco  = (intr_fall & st_q.ctrl.intr_tco) | ecc_hit.tco;
        st_d.rst_req  = st_q.rst_req | wd_rst | boot_to;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '{wd_en: 1'b0, intr_tco: 1'b0, ecc_ovr: 1'b0, ecc_route: DEST_SMI},
                      irq: '0, rst_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign smi       = st_q.irq.smi;
    assign nmi       = st_q.irq.nmi;
    assign serr      = st_q.irq.serr;
    assign tco_irq   = st_q.irq.tco;
    assign reset_req = st_q.rst_req;

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req); // R6
    AST_WD_SMI_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_smi |=> smi); // R2
    AST_WD_RST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |=> reset_req); // R3
    AST_BOOT_RST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        boot_to |=> reset_req); // R7
    AST_NO_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_valid && !intr_fall && !wd_smi) |=> !smi); // R1

endmodule

// File: tb/mec_event_ctrl_test.sv
module mec_event_ctrl_test;

    localparam int LIM = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        first_fetch = 1'b0;
    logic        intruder_n = 1'b1;
    logic        ecc_valid = 1'b0;
    logic [1:0]  ecc_code = '0;
    logic        smi, nmi, serr, tco_irq, reset_req, intrusion_flag;

    int checks = 0;
    int errors = 0;
    int smi_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mec_event_ctrl #(.BOOT_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .first_fetch(first_fetch), .intruder_n(intruder_n), .ecc_valid(ecc_valid),
        .ecc_code(ecc_code), .smi(smi), .nmi(nmi), .serr(serr), .tco_irq(tco_irq),
        .reset_req(reset_req), .intrusion_flag(intrusion_flag)
    );

    always @(negedge clk) if (smi) smi_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input bit with_fetch);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; first_fetch = with_fetch;
        @(negedge clk); first_fetch = 1'b0;
    endtask

    function automatic int outs();
        return {smi, nmi, serr, tco_irq};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc, cyc2, nsmi, s0;
        // R1: reset state
        do_reset(1'b1);
        chk(outs() == 0 && !reset_req && !intrusion_flag, "R1 reset outputs", outs(), 0);
        s0 = smi_seen;
        repeat (1100) @(negedge clk);
        chk(smi_seen == s0 && !reset_req, "R1 watchdog idle after reset", smi_seen - s0, 0);

        // R2/R3: sweep reload values
        for (int n = 0; n <= 6; n++) begin
            do_reset(1'b1);
            reg_wr(2'd0, 16'(n));
            reg_wr(2'd1, 16'h0001);
            cyc = 0;
            do begin @(negedge clk); cyc++; end while (!smi && cyc < 100);
            chk(cyc == n + 1, "R2 first expiry interval", cyc, n + 1);
            cyc2 = 0; nsmi = 0;
            do begin @(negedge clk); cyc2++; if (smi) nsmi++; end while (!reset_req && cyc2 < 100);
            chk(cyc2 == n + 1, "R3 second expiry interval", cyc2, n + 1);
            chk(nsmi == 0, "R3 no repeated smi", nsmi, 0);
        end

        // R4: kick after first expiry clears first-expiry state
        do_reset(1'b1);
        reg_wr(2'd0, 16'd4);
        reg_wr(2'd1, 16'h0001);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!smi && cyc < 100);
        reg_wr(2'd2, 16'd0);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!smi && !reset_req && cyc < 100);
        chk(smi && !reset_req && cyc == 5, "R4 kick rearms first stage", cyc, 5);
        // R4: frequent kicks hold off expiry
        do_reset(1'b1);
        reg_wr(2'd0, 16'd6);
        reg_wr(2'd1, 16'h0001);
        s0 = smi_seen;
        for (int k = 0; k < 10; k++) begin
            repeat (2) @(negedge clk);
            reg_wr(2'd2, 16'd0);
        end
        chk(smi_seen == s0 && !reset_req, "R4 periodic kicks prevent expiry", smi_seen - s0, 0);

        // R5: disable holds count
        do_reset(1'b1);
        reg_wr(2'd0, 16'd10);
        reg_wr(2'd1, 16'h0001);
        repeat (3) @(negedge clk);
        reg_wr(2'd1, 16'h0000);
        s0 = smi_seen;
        repeat (30) @(negedge clk);
        chk(smi_seen == s0, "R5 no event while disabled", smi_seen - s0, 0);
        reg_wr(2'd1, 16'h0001);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!smi && cyc < 100);
        chk(cyc == 7, "R5 resume from held count", cyc, 7);

        // R6: sticky reset request
        do_reset(1'b1);
        reg_wr(2'd0, 16'd1);
        reg_wr(2'd1, 16'h0001);
        repeat (10) @(negedge clk);
        chk(reset_req, "R6 reset request raised", reset_req, 1);
        reg_wr(2'd2, 16'd0);
        reg_wr(2'd1, 16'h0000);
        reg_wr(2'd3, 16'd0);
        repeat (20) @(negedge clk);
        chk(reset_req, "R6 reset request held", reset_req, 1);
        do_reset(1'b1);
        chk(!reset_req, "R6 cleared by rst_n", reset_req, 0);

        // R7: boot timeout without fetch
        do_reset(1'b0);
        repeat (LIM - 2) @(negedge clk);
        chk(!reset_req, "R7 no request before limit", reset_req, 0);
        @(negedge clk);
        chk(reset_req, "R7 request at limit edge", reset_req, 1);

        // R8: fetch on the last allowed edge
        do_reset(1'b0);
        repeat (LIM - 2) @(negedge clk);
        first_fetch = 1'b1;
        @(negedge clk); first_fetch = 1'b0;
        repeat (2 * LIM) @(negedge clk);
        chk(!reset_req, "R8 late-boundary fetch disarms", reset_req, 0);

        // R9/R10: intruder to SMI then TCO
        for (int r = 0; r < 2; r++) begin
            do_reset(1'b1);
            reg_wr(2'd1, r ? 16'h0002 : 16'h0000);
            intruder_n = 1'b0;
            @(negedge clk); @(negedge clk);
            chk(outs() == 0 && !intrusion_flag, "R9 no pulse before sync delay", outs(), 0);
            @(negedge clk);
            chk(outs() == (r ? 1 : 8), "R9 intrusion pulse destination", outs(), r ? 1 : 8);
            chk(intrusion_flag, "R10 flag set", intrusion_flag, 1);
            s0 = 0;
            for (int k = 0; k < 10; k++) begin @(negedge clk); if (outs() != 0) s0++; end
            chk(s0 == 0, "R9 held low gives one pulse", s0, 0);
            intruder_n = 1'b1;
            repeat (5) @(negedge clk);
            chk(intrusion_flag, "R10 flag sticky", intrusion_flag, 1);
            reg_wr(2'd3, 16'd0);
            chk(!intrusion_flag, "R10 flag cleared by write", intrusion_flag, 0);
        end

        // R11/R12: exhaustive ECC routing sweep
        do_reset(1'b1);
        for (int ov = 0; ov < 2; ov++) begin
            for (int rt = 0; rt < 4; rt++) begin
                reg_wr(2'd1, 16'((rt << 4) | (ov << 2)));
                for (int c = 0; c < 4; c++) begin
                    int sel, exp;
                    sel = ov ? rt : c;
                    exp = 8 >> sel;
                    ecc_valid = 1'b1; ecc_code = 2'(c);
                    @(negedge clk);
                    ecc_valid = 1'b0;
                    chk(outs() == exp, ov ? "R12 override route" : "R11 code route", outs(), exp);
                    @(negedge clk);
                    chk(outs() == 0, "R11 single-cycle pulse", outs(), 0);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule